// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block decides, cycle by cycle, which generated output clocks may toggle. It runs on the internal CPU clock and watches two active-low requests that arrive asynchronously. A stop request parks the CPU and memory clock groups low while every other group keeps running. A power-down request parks every group low, then removes the synthesizer (VCO) enable and after that the crystal oscillator enable. On release it brings both oscillators back and holds all clocks off for a programmable settling time before it restarts them.

Every clock source is modelled as a digital level, synchronous to the CPU clock, on `src_lvl`. Each group has one gate register, and it may change only in a cycle where its source is low. The gated clock is the source level ANDed with the gate, so no output can produce a shortened high phase when it stops or when it restarts. A configuration bit per group can force that group off. A minimum on-time rule stops the CPU group from being stopped again too soon after it restarts.

Top module: `clk_stop_pd_seq`

## Requirements
- R1: The stop request (`stop_req_n` low) passes through two synchronizing flops. The CPU group gate (bit 0) drops no later than the 4th rising clock edge after the request changes.
- R2: Group bits are 0 = CPU, 1 = memory, 2 = PCI, 3 = reference, 4 = 48 MHz. The stop request acts only on the groups selected by `STOP_MASK` (default bits 0 and 1). While it is held, those groups stay low and the others keep toggling.
- R3: After the stop request is released, the CPU group gate returns no later than the 4th rising edge.
- R4: A group's gate changes only in a cycle where that group's source is low. Every high phase of every gated clock is therefore a complete source high phase, including the first one after a restart.
- R5: Once the CPU gate has risen, a stop request cannot lower it until it has been high for `MIN_ON` cycles.
- R6: A group whose `cfg_en` bit is 0 stays low regardless of the stop and power-down state. A group whose bit is 1 toggles when nothing else stops it.
- R7: After `pdn_req_n` falls, every group gate goes low, each one at a low phase of its own source.
- R8: `vco_en` falls one cycle after all gates are seen low. `xtal_en` falls one cycle after `vco_en`.
- R9: While power-down is in effect, changes on the stop request have no visible effect on any output.
- R10: After `pdn_req_n` rises, `xtal_en` and `vco_en` return together on the 3rd edge. All gates stay low for `WAKE_CYC` further cycles before any group restarts.
- R11: In reset, every gate is 0 and both oscillator enables are 1. After reset, each enabled group starts at its first source low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_req_n | input | 1 | Asynchronous stop request for the masked groups, active low |
| pdn_req_n | input | 1 | Asynchronous power-down request, active low |
| cfg_en | input | N_GRP | Per-group enable from the configuration register |
| src_lvl | input | N_GRP | Current level of each free-running source clock |
| grp_en | output | N_GRP | Per-group gate, changes only while its source is low |
| gclk | output | N_GRP | Gated clock per group |
| vco_en | output | 1 | Synthesizer enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The bench sweeps all 32 configuration patterns over sources with mixed half-periods. A monitor measures every high pulse, so a design that updates a gate while its source is high fails on the short pulse that results. Stop and restart latency are measured in edges against the synchronizer depth, and a restart that is followed at once by a stop exposes a missing or short minimum on-time. The power-down test stamps the cycle in which the gates clear, the VCO enable falls and the crystal enable falls. It also toggles the stop request during power-down and times the wake-up hold, which catches wrong ordering, a stop that leaks through, and clocks that restart early.

// File: rtl/clkseq_pkg.sv
// Shared types for the clock stop and power-down sequencer.
// Assumes one clock domain: the internal CPU clock.
package clkseq_pkg;

    // Power-down sequencer states; the order is the shutdown order.
    typedef enum logic [2:0] {
        PD_RUN    = 3'd0,
        PD_DRAIN  = 3'd1,
        PD_VCOOFF = 3'd2,
        PD_OFF    = 3'd3,
        PD_WAKE   = 3'd4
    } pd_state_t;

endpackage

// File: rtl/clkseq_sync.sv
// Two-flop synchronizer bank for active-low asynchronous requests.
// Assumes the idle (inactive) level is 1, so reset loads all ones.
module clkseq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages in series; reset to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/clkseq_stop_ctrl.sv
// Stop-request qualifier with a minimum on-time for the CPU group.
// Assumes stop_n_s is already synchronized. cpu_gate is the CPU group gate.
// ext_off says the CPU group is held off for a reason other than the stop.
module clkseq_stop_ctrl #(
    parameter int MIN_ON = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n_s,
    input  logic cpu_gate,
    input  logic ext_off,
    output logic stop_hold
);

    localparam int CW = $clog2(MIN_ON + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_ON);

    logic [CW-1:0] on_cnt;
    logic          min_done;

    // Count the cycles the CPU gate has been high, saturating at MIN_ON.
    always_ff @(posedge clk) begin
        if (!rst_n || !cpu_gate) begin
            on_cnt <= '0;
        end else if (on_cnt != CNT_MAX) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    assign min_done  = (on_cnt == CNT_MAX);
    // A stop takes effect once the on-time is served, or if already stopped.
    assign stop_hold = !stop_n_s && (min_done || !cpu_gate);

    // R5: a stop-caused fall of the CPU gate needs a completed on-time.
    p_min_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_gate) && !$past(ext_off)) |-> $past(min_done));

endmodule

// File: rtl/clkseq_gate_bank.sv
// Per-group clock gate registers. Each gate follows its request only
// while its source is low, so the gated clock never has a runt high phase.
// Assumes src levels are synchronous to clk.
module clkseq_gate_bank #(
    parameter int N_GRP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_GRP-1:0] src,
    input  logic [N_GRP-1:0] want,
    output logic [N_GRP-1:0] gate,
    output logic [N_GRP-1:0] gclk
);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        // Load the requested gate state only during the source low phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gate[g] <= 1'b0;
            end else if (!src[g]) begin
                gate[g] <= want[g];
            end
        end

        assign gclk[g] = src[g] & gate[g];

        // R4: the gated clock falls only together with its source.
        p_fall_with_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gclk[g]) |-> $fell(src[g]));
        // R4: the gated clock rises only together with its source.
        p_rise_with_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gclk[g]) |-> $rose(src[g]));
    end

endmodule

// File: rtl/clkseq_pd_seq.sv
// Power-down sequencer: drains all gates, then drops the VCO enable and then
// the crystal enable. On release it restores both and holds the clocks off
// for WAKE_CYC cycles. Assumes pdn_s is already synchronized.
module clkseq_pd_seq
    import clkseq_pkg::*;
#(
    parameter int N_GRP    = 5,
    parameter int WAKE_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_s,
    input  logic [N_GRP-1:0] gates,
    output logic             pd_active,
    output logic             vco_en,
    output logic             xtal_en
);

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

    pd_state_t     state;
    logic [WW-1:0] wcnt;

    // Shutdown and wake-up state machine with the settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PD_RUN;
            wcnt  <= '0;
        end else begin
            case (state)
                PD_RUN:    if (!pdn_s) state <= PD_DRAIN;
                PD_DRAIN:  if (gates == '0) state <= PD_VCOOFF;
                PD_VCOOFF: state <= PD_OFF;
                PD_OFF: begin
                    if (pdn_s) begin
                        state <= PD_WAKE;
                        wcnt  <= '0;
                    end
                end
                PD_WAKE: begin
                    if (wcnt == WAKE_LAST) state <= PD_RUN;
                    else                   wcnt  <= wcnt + 1'b1;
                end
                default:   state <= PD_RUN;
            endcase
        end
    end

    // Decode the outputs from the state.
    assign pd_active = (state != PD_RUN);
    assign vco_en    = (state == PD_RUN) || (state == PD_DRAIN) || (state == PD_WAKE);
    assign xtal_en   = (state != PD_OFF);

    // R8: the VCO enable drops only once every gate is already low.
    p_vco_after_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> ($past(gates) == '0) && (gates == '0));
    // R8: the crystal enable drops only after the VCO enable is off.
    p_xtal_after_vco_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xtal_en) |-> (!vco_en && $past(!vco_en)));
    // R10: no gate is open while the wake-up counter runs.
    p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAKE) |-> (gates == '0));

endmodule

// File: rtl/clk_stop_pd_seq.sv
// Top level: synchronizes both requests, forms per-group gate requests from
// the configuration, the stop qualifier and the power-down state, and drives
// the gate bank and the oscillator enables. Assumes one CPU clock domain.
module clk_stop_pd_seq #(
    parameter int               N_GRP     = 5,
    parameter logic [N_GRP-1:0] STOP_MASK = 5'b00011,
    parameter int               CPU_IDX   = 0,
    parameter int               MIN_ON    = 100,
    parameter int               WAKE_CYC  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic             pdn_req_n,
    input  logic [N_GRP-1:0] cfg_en,
    input  logic [N_GRP-1:0] src_lvl,
    output logic [N_GRP-1:0] grp_en,
    output logic [N_GRP-1:0] gclk,
    output logic             vco_en,
    output logic             xtal_en
);

    logic [1:0]       req_s;
    logic             stop_hold;
    logic             pd_active;
    logic [N_GRP-1:0] want;

    clkseq_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pdn_req_n, stop_req_n}),
        .q     (req_s)
    );

    clkseq_stop_ctrl #(.MIN_ON(MIN_ON)) u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_n_s  (req_s[0]),
        .cpu_gate  (grp_en[CPU_IDX]),
        .ext_off   (!cfg_en[CPU_IDX] || pd_active),
        .stop_hold (stop_hold)
    );

    clkseq_pd_seq #(.N_GRP(N_GRP), .WAKE_CYC(WAKE_CYC)) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn_s     (req_s[1]),
        .gates     (grp_en),
        .pd_active (pd_active),
        .vco_en    (vco_en),
        .xtal_en   (xtal_en)
    );

    // Gate request per group: configured on, not powering down, not stopped.
    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            want[g] = cfg_en[g] && !pd_active && !(STOP_MASK[g] && stop_hold);
        end
    end

    clkseq_gate_bank #(.N_GRP(N_GRP)) u_gates (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_lvl),
        .want  (want),
        .gate  (grp_en),
        .gclk  (gclk)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        // R6: a disabled group cannot open its gate at a source low phase.
        p_cfg_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_en[g] && !src_lvl[g]) |=> !grp_en[g]);
    end

endmodule

// File: tb/sim_clk_stop_pd_seq.sv
`timescale 1ns/100ps
module sim_clk_stop_pd_seq;

    localparam int NG   = 5;
    localparam int MINO = 20;
    localparam int WAKE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic          pd_n = 1'b1;
    logic [NG-1:0] cfg = '1;
    logic [NG-1:0] src = '0;
    logic [NG-1:0] grp_en, gclk;
    logic          vco_en, xtal_en;

    int checks = 0;
    int errors = 0;
    int sc[NG];
    int hi_len[NG];
    int rises[NG];
    logic [NG-1:0] prev;

    always #2.5 clk = ~clk;

    clk_stop_pd_seq #(.N_GRP(NG), .STOP_MASK(5'b00011), .CPU_IDX(0),
                      .MIN_ON(MINO), .WAKE_CYC(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req_n(stop_n), .pdn_req_n(pd_n),
        .cfg_en(cfg), .src_lvl(src), .grp_en(grp_en), .gclk(gclk),
        .vco_en(vco_en), .xtal_en(xtal_en));

    function automatic int half(int g);
        case (g)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Free-running sources, updated 1 ns after each rising edge.
    initial begin
        for (int g = 0; g < NG; g++) sc[g] = 0;
        forever begin
            @(posedge clk);
            #1;
            for (int g = 0; g < NG; g++) begin
                if (sc[g] == half(g) - 1) begin
                    sc[g] = 0;
                    src[g] = ~src[g];
                end else sc[g]++;
            end
        end
    end

    // R4: every high pulse of a gated clock must be a full source high phase.
    initial for (int g = 0; g < NG; g++) hi_len[g] = 0;
    always @(negedge clk) begin
        for (int g = 0; g < NG; g++) begin
            if (gclk[g]) hi_len[g]++;
            else if (hi_len[g] > 0) begin
                chk(hi_len[g] == half(g), "R4 pulse width", hi_len[g], half(g));
                hi_len[g] = 0;
            end
        end
    end

    task automatic count_rises(input int cyc);
        for (int g = 0; g < NG; g++) rises[g] = 0;
        prev = gclk;
        repeat (cyc) begin
            @(negedge clk);
            for (int g = 0; g < NG; g++) if (gclk[g] && !prev[g]) rises[g]++;
            prev = gclk;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, ng, nv, nx, bad;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(grp_en == '0, "R11 reset gates", grp_en, 0);
        chk(vco_en && xtal_en, "R11 reset osc", {vco_en, xtal_en}, 3);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(grp_en == '1, "R11 start after reset", grp_en, 31);

        // R6: exhaustive sweep over the configuration bits.
        for (int p = 0; p < 32; p++) begin
            cfg = p[NG-1:0];
            repeat (12) @(negedge clk);
            count_rises(24);
            for (int g = 0; g < NG; g++)
                chk((rises[g] > 0) == p[g], "R6 cfg gating", rises[g], p[g]);
        end
        cfg = '1;
        repeat (MINO + 12) @(negedge clk);

        // R1: stop latency.
        stop_n = 1'b0;
        n = 0;
        while (grp_en[0] && n < 12) begin @(negedge clk); n++; end
        chk(n <= 4, "R1 stop latency", n, 4);
        repeat (8) @(negedge clk);
        count_rises(30);
        chk(rises[0] == 0 && rises[1] == 0, "R2 stopped groups", rises[0] + rises[1], 0);
        chk(rises[2] > 0 && rises[3] > 0 && rises[4] > 0, "R2 other groups run",
            (rises[2] > 0) + (rises[3] > 0) + (rises[4] > 0), 3);

        // R3: restart latency.
        stop_n = 1'b1;
        n = 0;
        while (!grp_en[0] && n < 12) begin @(negedge clk); n++; end
        chk(n <= 4, "R3 restart latency", n, 4);

        // R5: stop right after restart must wait for the minimum on-time.
        stop_n = 1'b0;
        n = 1;
        while (grp_en[0] && n < MINO + 20) begin @(negedge clk); if (grp_en[0]) n++; end
        chk(n >= MINO && n <= MINO + 3, "R5 min on-time", n, MINO);
        stop_n = 1'b1;
        repeat (MINO + 12) @(negedge clk);
        chk(grp_en == '1, "R3 all running again", grp_en, 31);

        // R7/R8: power-down ordering.
        pd_n = 1'b0;
        ng = -1; nv = -1; nx = -1;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (ng < 0 && grp_en == '0) ng = c;
            if (nv < 0 && !vco_en) nv = c;
            if (nx < 0 && !xtal_en) nx = c;
        end
        chk(ng > 0 && ng <= 10, "R7 gates drained", ng, 10);
        chk(nv == ng + 1, "R8 vco after gates", nv, ng + 1);
        chk(nx == nv + 1, "R8 xtal after vco", nx, nv + 1);

        // R9: stop toggling during power-down has no effect.
        bad = 0;
        for (int c = 0; c < 60; c++) begin
            if (c == 10) stop_n = 1'b0;
            if (c == 30) stop_n = 1'b1;
            if (c == 45) stop_n = 1'b0;
            @(negedge clk);
            if (gclk != '0 || grp_en != '0 || vco_en || xtal_en) bad++;
        end
        chk(bad == 0, "R9 stop ignored in power-down", bad, 0);

        // R10: wake-up ordering and hold time (stop still low).
        pd_n = 1'b1;
        nx = -1; ng = -1;
        for (int c = 1; c <= WAKE + 20; c++) begin
            @(negedge clk);
            if (nx < 0 && xtal_en) begin
                nx = c;
                chk(vco_en, "R10 vco with xtal", vco_en, 1);
            end
            if (ng < 0 && grp_en != '0) ng = c;
        end
        chk(nx == 3, "R10 osc return", nx, 3);
        chk(ng >= WAKE + 4 && ng <= WAKE + 11, "R10 wake hold", ng, WAKE + 4);
        repeat (10) @(negedge clk);
        chk(grp_en == 5'b11100, "R2 stop still held after wake", grp_en, 28);

        stop_n = 1'b1;
        n = 0;
        while (!grp_en[0] && n < 12) begin @(negedge clk); n++; end
        chk(n <= 4, "R3 restart after wake", n, 4);
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule